// File: doc/BRIEF.md
# Read Data Latency and Byte Mask Pipeline

This block sits on the data side of a synchronous graphics DRAM model, between the read port of the storage array and the 32-bit data pins. Each word that the array returns is held back by the CAS latency currently in force. The latency can be set at run time to one, two or three clocks. A per-byte mask is applied to the word as it leaves. On the read path the mask takes effect two clocks after it is sampled. On the write path it takes effect in the same cycle.

The output side gives the delayed word and one output-enable bit per byte. An enable bit that is low stands for a byte at high impedance, and the data bits of that byte are driven to zero. The write side gives a byte-enable vector that the array uses for the current write cycle.

A clock-enable input suspends the whole pipeline. When it is sampled low, every stage holds its value from the following clock edge on.

Top module: `rdq_out_pipe`

## Requirements
- R1: A word presented with `rd_valid` high at a clock edge appears on `dq_out` with its byte enables high after exactly L further advancing clock edges, where L is the CAS latency in force. With L=1 it is visible right after the edge that captured it.
- R2: The `cas_lat` code selects the latency: 1 means one clock, 2 means two clocks, 3 means three clocks. The code 0 is ignored and the previous latency stays. After reset the latency is 1.
- R3: A new `cas_lat` value is taken only at an advancing edge where no read word is held in any of the three delay stages. While words are in flight, the previous latency stays in force.
- R4: `dqm` bit 0 governs data bits 7..0, bit 1 governs 15..8, bit 2 governs 23..16 and bit 3 governs 31..24. This mapping holds on both the read path and the write path.
- R5: On reads, a `dqm` bit sampled high at an advancing edge clears the matching `dq_oe` bit after the second advancing edge from it. This timing is the same for every CAS latency.
- R6: A `dqm` bit affects only the cycle in which it is sampled. A lone high bit disables its byte for exactly one output cycle.
- R7: A `dq_oe` bit is high only when a valid read word sits at the selected output tap and that byte's delayed mask bit is low. A byte whose enable is low shows zero on `dq_out`.
- R8: `wr_be` equals the bitwise inverse of `dqm` in the same cycle when `wr_en` is high and the pipeline is not suspended. Otherwise `wr_be` is zero.
- R9: If `cke` is sampled low at an edge, the next edge does not advance any stage or register the latency. `dq_out` and `dq_oe` hold their values. The pipeline advances again at the edge after the one where `cke` is sampled high.
- R10: While `rst_n` is low at a clock edge, the pipeline empties, the latency returns to 1 and the block is not suspended. `dq_out`, `dq_oe` and `wr_be` then read zero while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable; low suspends the pipeline from the next edge |
| cas_lat | input | 2 | Requested CAS latency code (1, 2 or 3; 0 ignored) |
| rd_valid | input | 1 | Array read word valid this cycle |
| rd_data | input | 32 | Array read word |
| dqm | input | 4 | Per-byte mask, bit b covers bits 8b+7..8b |
| wr_en | input | 1 | Current cycle is a write data cycle |
| dq_out | output | 32 | Delayed read word; disabled bytes read zero |
| dq_oe | output | 4 | Per-byte output enable; low means high impedance |
| wr_be | output | 4 | Per-byte write enable for the array this cycle |

## Verification
The assertions assume that `cas_lat` may change at any time and that its changes are filtered by the in-flight rule. They also assume that `cke` is an ordinary synchronous input, so a suspended edge can follow any other edge, including one with a read or a mask in progress. The stimulus draws every input from a seeded random source. Suspend cycles make up about one in seven cycles and latency requests arrive often, so requests collide with words that are still in flight. Directed runs put a word through each latency in turn, walk a single mask bit across every byte, test the ignored zero code, and freeze the pipeline in the middle of a burst.

// File: rtl/rdq_pkg.sv
package rdq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BYTES  = DATA_W / 8;
  localparam int unsigned MAX_CL = 3;
  localparam int unsigned CL_W   = $clog2(MAX_CL + 1);
  localparam int unsigned MASK_DLY = 2;

  typedef logic [CL_W-1:0] cl_t;

  // a latency code is usable when it names 1..MAX_CL
  function automatic logic cl_ok(input cl_t c);
    return (c != '0) && (int'(c) <= MAX_CL);
  endfunction

  // stage index that yields a given latency
  function automatic cl_t tap_of(input cl_t c);
    return c - cl_t'(1);
  endfunction

  // widen a per-byte enable into a per-bit enable
  function automatic logic [DATA_W-1:0] spread(input logic [BYTES-1:0] be);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < BYTES; b++) r[b*8 +: 8] = {8{be[b]}};
    return r;
  endfunction
endpackage

// File: rtl/rdq_lat_pipe.sv
module rdq_lat_pipe #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 3,
  localparam int unsigned SW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_v,
  input  logic [DW-1:0] in_d,
  input  logic [SW-1:0] tap_sel,
  output logic          out_v,
  output logic [DW-1:0] out_d,
  output logic          busy
);
  logic [DW-1:0] st_d [DEPTH];
  logic          st_v [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_v[0] <= 1'b0;
          st_d[0] <= '0;
        end else if (adv) begin
          st_v[0] <= in_v;
          st_d[0] <= in_d;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_v[i] <= 1'b0;
          st_d[i] <= '0;
        end else if (adv) begin
          st_v[i] <= st_v[i-1];
          st_d[i] <= st_d[i-1];
        end
      end
    end
  end

  always_comb begin
    out_v = 1'b0;
    out_d = '0;
    busy  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      busy = busy | st_v[i];
      if (SW'(i) == tap_sel) begin
        out_v = st_v[i];
        out_d = st_d[i];
      end
    end
  end

  // R1: an advancing edge captures the incoming valid flag at the head stage
  p_head_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (st_v[0] == $past(in_v)));

  // R9: a held edge leaves the head stage untouched
  p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(st_v[0]) && $stable(st_d[0])));
endmodule

// File: rtl/rdq_mask_pipe.sv
module rdq_mask_pipe #(
  parameter int unsigned NB  = 4,
  parameter int unsigned DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [NB-1:0] mask_in,
  output logic [NB-1:0] mask_dly
);
  logic [NB-1:0] m_st [DLY];

  for (genvar i = 0; i < DLY; i++) begin : g_mst
    always_ff @(posedge clk) begin
      if (!rst_n)   m_st[i] <= '0;
      else if (adv) m_st[i] <= (i == 0) ? mask_in : m_st[(i == 0) ? 0 : i-1];
    end
  end

  assign mask_dly = m_st[DLY-1];

  // R5: the first mask stage records the sampled mask on an advancing edge
  p_mask_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (m_st[0] == $past(mask_in)));

  // R9: a held edge leaves the delayed mask unchanged
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(mask_dly));
endmodule

// File: rtl/rdq_wr_gate.sv
module rdq_wr_gate #(
  parameter int unsigned NB = 4
) (
  input  logic          wr_en,
  input  logic          adv,
  input  logic [NB-1:0] mask_in,
  output logic [NB-1:0] be
);
  always_comb begin
    be = '0;
    if (wr_en && adv) be = ~mask_in;
  end
endmodule

// File: rtl/rdq_out_pipe.sv
module rdq_out_pipe
  import rdq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic [CL_W-1:0]   cas_lat,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [BYTES-1:0]  dqm,
  input  logic              wr_en,
  output logic [DATA_W-1:0] dq_out,
  output logic [BYTES-1:0]  dq_oe,
  output logic [BYTES-1:0]  wr_be
);
  logic              cke_d;
  logic              adv;
  cl_t               cl_cur;
  logic              busy;
  logic              tap_v;
  logic [DATA_W-1:0] tap_d;
  logic [BYTES-1:0]  mask_late;
  logic              cl_take;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_d <= 1'b1;
    else        cke_d <= cke;
  end
  assign adv = cke_d;

  assign cl_take = adv && !busy && cl_ok(cas_lat);

  always_ff @(posedge clk) begin
    if (!rst_n)       cl_cur <= cl_t'(1);
    else if (cl_take) cl_cur <= cas_lat;
  end

  rdq_lat_pipe #(.DW(DATA_W), .DEPTH(MAX_CL)) u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .in_v    (rd_valid),
    .in_d    (rd_data),
    .tap_sel (tap_of(cl_cur)),
    .out_v   (tap_v),
    .out_d   (tap_d),
    .busy    (busy)
  );

  rdq_mask_pipe #(.NB(BYTES), .DLY(MASK_DLY)) u_msk (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .mask_in  (dqm),
    .mask_dly (mask_late)
  );

  rdq_wr_gate #(.NB(BYTES)) u_wr (
    .wr_en   (wr_en),
    .adv     (adv),
    .mask_in (dqm),
    .be      (wr_be)
  );

  assign dq_oe  = tap_v ? ~mask_late : '0;
  assign dq_out = tap_d & spread(dq_oe);

  // R2: the latency in force is always a legal code
  p_cl_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cl_ok(cl_cur));

  // R3: while words are in flight the latency cannot move
  p_cl_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cl_cur));

  // R7: no byte enable without a valid word leaving the pipe
  p_oe_needs_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != '0) |-> tap_v);

  // R7: disabled bytes read zero
  p_off_bytes_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((dq_out & ~spread(dq_oe)) == '0));

  // R8: a suspended cycle never enables a write byte
  p_wr_suspended_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |-> (wr_be == '0));

  // R9: outputs hold across a held edge
  p_out_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(dq_out) && $stable(dq_oe)));
endmodule

// File: tb/rdq_out_pipe_test.sv
module rdq_out_pipe_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic [1:0]  cas_lat = 2'd1;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic [3:0]  dqm = '0;
  logic        wr_en = 1'b0;
  logic [31:0] dq_out;
  logic [3:0]  dq_oe;
  logic [3:0]  wr_be;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // independent reference state
  logic        e_cke;
  int          e_cl;
  logic        e_v [3];
  logic [31:0] e_d [3];
  logic [3:0]  e_m1, e_m2;

  always #(CLK_NS/2) clk = ~clk;

  rdq_out_pipe uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cas_lat(cas_lat),
    .rd_valid(rd_valid), .rd_data(rd_data), .dqm(dqm), .wr_en(wr_en),
    .dq_out(dq_out), .dq_oe(dq_oe), .wr_be(wr_be)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired: actual=%0d cycles expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] byte_bits(input logic [3:0] be);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b+7 -: 8] = 8'hFF;
    return r;
  endfunction

  function automatic logic [3:0] exp_oe();
    return e_v[e_cl-1] ? (4'hF ^ e_m2) : 4'h0;
  endfunction

  function automatic logic [31:0] exp_dq();
    return e_d[e_cl-1] & byte_bits(exp_oe());
  endfunction

  task automatic model_reset();
    e_cke = 1'b1; e_cl = 1; e_m1 = '0; e_m2 = '0;
    for (int i = 0; i < 3; i++) begin e_v[i] = 1'b0; e_d[i] = '0; end
  endtask

  task automatic model_edge(input logic c, v, input logic [31:0] d,
                            input logic [3:0] m, input logic [1:0] cl);
    logic adv_now;
    adv_now = e_cke;
    e_cke = c;
    if (adv_now) begin
      if (!(e_v[0] || e_v[1] || e_v[2]) && cl != 2'd0) e_cl = int'(cl);
      e_v[2] = e_v[1]; e_d[2] = e_d[1];
      e_v[1] = e_v[0]; e_d[1] = e_d[0];
      e_v[0] = v;      e_d[0] = d;
      e_m2 = e_m1;     e_m1 = m;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check write enables, clock, check outputs
  task automatic tick(input string tag, input logic c, v, input logic [31:0] d,
                      input logic [3:0] m, input logic w, input logic [1:0] cl);
    cke = c; rd_valid = v; rd_data = d; dqm = m; wr_en = w; cas_lat = cl;
    #1;
    chk("R8 R4 write enable", {28'd0, wr_be}, {28'd0, (w && e_cke) ? ~m : 4'h0});
    @(posedge clk);
    model_edge(c, v, d, m, cl);
    @(negedge clk);
    chk(tag, {28'd0, dq_oe}, {28'd0, exp_oe()});
    chk(tag, dq_out, exp_dq());
  endtask

  task automatic idle(input string tag, input int n, input logic [1:0] cl);
    for (int i = 0; i < n; i++) tick(tag, 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, cl);
  endtask

  initial begin
    int seed;
    int lat_seen;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset oe", {28'd0, dq_oe}, 32'd0);
    chk("R10 reset data", dq_out, 32'd0);
    chk("R10 reset write", {28'd0, wr_be}, 32'd0);
    rst_n = 1'b1;

    // R1 R2: one word through each latency, counting cycles to its arrival
    for (int l = 1; l <= 3; l++) begin
      idle("R2 latency set", 4, 2'(l));
      tick("R1 inject", 1'b1, 1'b1, 32'hA5A5_0000 + l, 4'h0, 1'b0, 2'(l));
      lat_seen = (dq_oe == 4'hF) ? 1 : 0;
      for (int k = 2; k <= 4; k++) begin
        tick("R1 drain", 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 2'(l));
        if (dq_oe == 4'hF && lat_seen == 0) lat_seen = k;
      end
      chk("R1 latency count", lat_seen, l);
    end

    // R2: code 0 ignored, latency stays 3
    idle("R2 zero code", 3, 2'd0);
    tick("R2 zero code", 1'b1, 1'b1, 32'h1234_5678, 4'h0, 1'b0, 2'd0);
    idle("R2 zero code", 4, 2'd0);

    // R3: request latency 1 while a latency-3 word is in flight
    idle("R3 setup", 3, 2'd3);
    tick("R3 inflight", 1'b1, 1'b1, 32'hDEAD_BEEF, 4'h0, 1'b0, 2'd3);
    idle("R3 inflight", 5, 2'd1);

    // R4 R5: walk one mask bit over each byte under each latency
    for (int l = 1; l <= 3; l++) begin
      idle("R5 setup", 4, 2'(l));
      for (int b = 0; b < 4; b++)
        tick("R4 R5 byte mask", 1'b1, 1'b1, 32'h0102_0304 * (b + 1), 4'(1 << b), 1'b0, 2'(l));
      idle("R5 drain", 4, 2'(l));
    end

    // R6: a lone mask in a burst, then mask idle
    idle("R6 setup", 4, 2'd2);
    tick("R6 lone mask", 1'b1, 1'b1, 32'hCAFE_F00D, 4'hF, 1'b0, 2'd2);
    for (int i = 0; i < 4; i++)
      tick("R6 lone mask", 1'b1, 1'b1, 32'h1111_1111 * i, 4'h0, 1'b0, 2'd2);
    idle("R6 drain", 4, 2'd2);

    // R9: suspend in the middle of a burst
    for (int i = 0; i < 3; i++)
      tick("R9 burst", 1'b1, 1'b1, 32'h7000_0000 + i, 4'h2, 1'b1, 2'd2);
    tick("R9 suspend", 1'b0, 1'b1, 32'hBAD0_0001, 4'h0, 1'b1, 2'd2);
    tick("R9 suspend", 1'b0, 1'b1, 32'hBAD0_0002, 4'hF, 1'b1, 2'd2);
    tick("R9 resume", 1'b1, 1'b1, 32'h7000_0009, 4'h0, 1'b1, 2'd2);
    idle("R9 drain", 4, 2'd2);

    // R7 R8 R3 R9: random mix
    for (int i = 0; i < 2000; i++) begin
      logic c, v, w;
      logic [1:0] cl;
      c  = ($urandom % 7) != 0;
      v  = ($urandom % 2) == 0;
      w  = ($urandom % 3) == 0;
      cl = 2'($urandom % 4);
      tick("R7 random", c, v, $urandom, 4'($urandom), w, cl);
    end

    // R10: reset in mid flight
    tick("R10 pre", 1'b1, 1'b1, 32'h5555_AAAA, 4'h0, 1'b0, 2'd3);
    rst_n = 1'b0;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    chk("R10 mid reset oe", {28'd0, dq_oe}, 32'd0);
    chk("R10 mid reset data", dq_out, 32'd0);
    rst_n = 1'b1;
    tick("R10 after", 1'b1, 1'b1, 32'h0F0F_0F0F, 4'h0, 1'b0, 2'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule